// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. The default configuration is W = 4. An AND-gate array builds the partial-product rows. Each following row of full adders combines one new partial-product row with the sum and carry vectors handed down from the row above. A full adder never passes its carry to the next adder in the same row. The carry moves one column to the left and enters the row below. After the last carry-save row, a ripple-carry adder merges the remaining sum and carry vectors into the final product.

A register stage follows every adder row, so the clock period is set by one row of full adders and not by the whole array. A new operand pair is accepted on every clock. A valid flag moves through the stages next to the data. Low product bits that settle in early rows are passed forward unchanged, so all 2W bits leave the last register together. The configuration must satisfy W >= 2.

Top module: `pipelined_csa_mul`

## Requirements
- R1: When `out_valid` is 1, `product` equals `op_a * op_b` for the accepted pair. Both operands are treated as unsigned. The result is exact over all 2W bits.
- R2: The latency is exactly W clock cycles. A pair is captured at a rising edge while `in_valid` is 1. Its result appears, with `out_valid` = 1, right after the W-th rising edge, counting the capture edge as the first.
- R3: A pair is accepted on every rising edge where `in_valid` is 1, including consecutive edges. Results leave in the order they entered, and each accepted pair produces exactly one result.
- R4: An edge with `in_valid` = 0 produces no result: `out_valid` stays 0 in the cycle that edge would map to, whatever values the operands hold.
- R5: The synchronous `rst` clears every stage valid flag. `out_valid` is 0 after any edge where `rst` is 1. Pairs that were in flight at reset never appear at the output.
- R6: Each carry-save row keeps the arithmetic value: the sum vector plus the carry vector equals the product of the multiplicand with the multiplier bits consumed so far.
- R7: After row r, carry-vector bits r down to 0 are zero. The low sum bits settled by earlier rows move forward unchanged.
- R8: The final ripple-carry row adds the last sum and carry vectors, and that sum becomes the product register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| out_valid | output | 1 | Product present this cycle |
| product | output | 2W | Unsigned product |

## Verification
Two pipeline events can fall in the same clock: a new pair entering the first row and an older pair leaving the final ripple row. Other pairs are still in the middle stages at that moment. The bench provokes this by feeding all 256 four-bit operand pairs on consecutive clocks, then a random stream with idle gaps. Every completed product is checked against an independently computed product and against the cycle in which it was expected. A reset applied while several pairs are in flight checks that in-flight data is flushed and does not leak into later results.

// File: rtl/csa_row.sv
module csa_row #(
  parameter int W   = 4,
  parameter int ROW = 1
) (
  input  logic [W-1:0]   mcand,
  input  logic           qbit,
  input  logic [2*W-1:0] s_in,
  input  logic [2*W-1:0] c_in,
  output logic [2*W-1:0] s_out,
  output logic [2*W-1:0] c_out
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pp;

  // partial-product row weighted by 2^ROW
  for (genvar i = 0; i < PW; i++) begin : g_pp
    if (i >= ROW && i < ROW + W) begin : g_on
      assign pp[i] = mcand[i-ROW] & qbit;
    end else begin : g_off
      assign pp[i] = 1'b0;
    end
  end

  // one full adder per column; carry goes one column left into the next row
  assign c_out[0] = 1'b0;
  for (genvar i = 0; i < PW; i++) begin : g_fa
    assign s_out[i] = s_in[i] ^ c_in[i] ^ pp[i];
    if (i < PW - 1) begin : g_cy
      assign c_out[i+1] = (s_in[i] & c_in[i]) | (s_in[i] & pp[i]) | (c_in[i] & pp[i]);
    end
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] sum
);
  function automatic logic [PW-1:0] ripple(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic cy;
    logic [PW-1:0] r;
    cy = 1'b0;
    for (int i = 0; i < PW; i++) begin
      r[i] = a[i] ^ b[i] ^ cy;
      cy   = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
    end
    return r;
  endfunction

  assign sum = ripple(x, y);
endmodule

// File: rtl/pipelined_csa_mul.sv
module pipelined_csa_mul #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int PW   = 2 * W;
  localparam int ROWS = W - 1;   // carry-save rows, each followed by a register

  // n low ones in a PW-bit vector
  function automatic logic [PW-1:0] low_ones(input int n);
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = (i < n);
    return m;
  endfunction

  // value the array must hold after consuming multiplier bits 0..r
  function automatic logic [PW-1:0] partial_prod(input logic [W-1:0] a,
                                                 input logic [W-1:0] b,
                                                 input int r);
    logic [PW-1:0] acc;
    acc = '0;
    for (int j = 0; j < W; j++)
      if (j <= r && b[j]) acc = acc + (PW'(a) << j);
    return acc;
  endfunction

  // combinational row outputs
  logic [PW-1:0] row_s [ROWS];
  logic [PW-1:0] row_c [ROWS];
  // stage registers
  logic [PW-1:0] st_s  [ROWS];
  logic [PW-1:0] st_c  [ROWS];
  logic [W-1:0]  st_a  [ROWS];
  logic [W-1:0]  st_b  [ROWS];
  logic          st_v  [ROWS];

  // row 0 seed: m & q0, no carries yet
  logic [PW-1:0] seed_s;
  assign seed_s = {{W{1'b0}}, op_a & {W{op_b[0]}}};

  csa_row #(.W(W), .ROW(1)) u_row1 (
    .mcand(op_a), .qbit(op_b[1]), .s_in(seed_s), .c_in('0),
    .s_out(row_s[0]), .c_out(row_c[0])
  );

  for (genvar k = 1; k < ROWS; k++) begin : g_rows
    csa_row #(.W(W), .ROW(k + 1)) u_row (
      .mcand(st_a[k-1]), .qbit(st_b[k-1][k+1]),
      .s_in(st_s[k-1]), .c_in(st_c[k-1]),
      .s_out(row_s[k]), .c_out(row_c[k])
    );
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < ROWS; k++) begin
      st_s[k] <= row_s[k];
      st_c[k] <= row_c[k];
      st_a[k] <= (k == 0) ? op_a : st_a[k-1];
      st_b[k] <= (k == 0) ? op_b : st_b[k-1];
      if (rst) st_v[k] <= 1'b0;
      else     st_v[k] <= (k == 0) ? in_valid : st_v[k-1];
    end
  end

  // final carry-propagate row
  logic [PW-1:0] merged;
  ripple_add #(.PW(PW)) u_rca (
    .x(st_s[ROWS-1]), .y(st_c[ROWS-1]), .sum(merged)
  );

  always_ff @(posedge clk) begin
    product <= merged;
    if (rst) out_valid <= 1'b0;
    else     out_valid <= st_v[ROWS-1];
  end

  // ---------------- assertions ----------------
  p_first_valid_r4: assert property (@(posedge clk) disable iff (rst)
    st_v[0] == $past(in_valid));

  for (genvar k = 0; k < ROWS; k++) begin : g_chk
    // R6: sum + carry holds the partial product of rows 0..k+1
    p_csa_value_r6: assert property (@(posedge clk) disable iff (rst)
      st_v[k] |-> (st_s[k] + st_c[k]) == partial_prod(st_a[k], st_b[k], k + 1));
    // R7: carries never land in columns already retired
    p_carry_retired_r7: assert property (@(posedge clk) disable iff (rst)
      st_v[k] |-> (st_c[k] & low_ones(k + 2)) == '0);
    if (k > 0) begin : g_hold
      p_valid_step_r3: assert property (@(posedge clk) disable iff (rst)
        st_v[k] == $past(st_v[k-1]));
      p_low_hold_r7: assert property (@(posedge clk) disable iff (rst)
        st_v[k] |-> (st_s[k] & low_ones(k + 1)) == ($past(st_s[k-1]) & low_ones(k + 1)));
    end
  end

  p_out_step_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(st_v[ROWS-1]));
  p_final_add_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> product == $past(st_s[ROWS-1] + st_c[ROWS-1]));
  p_reset_clear_r5: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/sim_pipelined_csa_mul.sv
module sim_pipelined_csa_mul;
  localparam int W   = 4;
  localparam int PW  = 2 * W;
  localparam int LAT = W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          out_valid;
  logic [PW-1:0] product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [PW-1:0] exp_q [$];
  int            when_q [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pipelined_csa_mul #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product)
  );

  // driver: present one cycle of stimulus, record what must come out and when
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input bit v);
    @(negedge clk);
    op_a = a;
    op_b = b;
    in_valid = v;
    if (v) begin
      exp_q.push_back(PW'(a) * PW'(b));
      when_q.push_back(cyc + LAT);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: result with nothing pending, actual product=%0d expected no out_valid", product);
      end else begin
        logic [PW-1:0] e;
        int t;
        e = exp_q.pop_front();
        t = when_q.pop_front();
        checks++;
        if (product !== e) begin
          errors++;
          $display("FAIL R1: product actual=%0d expected=%0d", product, e);
        end
        checks++;
        if (cyc != t) begin
          errors++;
          $display("FAIL R2: result cycle actual=%0d expected=%0d", cyc, t);
        end
      end
    end
  end

  task automatic check_idle(input string req);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: out_valid actual=%b expected=0", req, out_valid);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R5");                       // R5: reset state
    @(negedge clk);
    rst = 1'b0;

    // R1 R3 R6 R7 R8: every 4-bit pair, back to back
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        send(W'(a), W'(b), 1'b1);

    // R4: random stream with idle gaps carrying junk operands
    for (int n = 0; n < 300; n++)
      send(W'($urandom), W'($urandom), ($urandom % 3) != 0);
    send('0, '0, 1'b0);
    repeat (LAT + 2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin              // R3: each pair gave one result
      errors++;
      $display("FAIL R3: pending results actual=%0d expected=0", exp_q.size());
    end

    // R5: reset with pairs in flight
    send(4'd15, 4'd15, 1'b1);
    send(4'd9,  4'd7,  1'b1);
    send(4'd3,  4'd12, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    exp_q.delete();
    when_q.delete();
    @(negedge clk);
    check_idle("R5");
    @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < LAT + 2; n++) begin
      @(negedge clk);
      check_idle("R5");
    end

    // R1: corners after reset
    send(4'd15, 4'd15, 1'b1);
    send(4'd0,  4'd15, 1'b1);
    send(4'd15, 4'd1,  1'b1);
    send(4'd8,  4'd8,  1'b1);
    send('0, '0, 1'b0);
    repeat (LAT + 2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3: pending results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
    finish_run();
  end
endmodule